// File: doc/BRIEF.md
# Vector Mask Generation and Merge Unit

This unit owns a small vector register file together with a per-element mask register and an active-length register. Commands arrive one at a time on a flat command port. Two commands act on scalar state only: one loads the mask straight from a scalar operand, the other sets the active length. Three commands walk the active elements of the vector registers, one element per clock and lowest element first. The first builds the mask by testing a single vector against a chosen condition. The second builds it from a signed less-than comparison of two vectors. The third selects each destination element from one of two sources according to the mask.

A compare followed by a merge gives an element-wise minimum or maximum. A condition test followed by a merge replaces selected elements without a branch. Elements at or beyond the active length are never written. A direct element write port and a combinational element read port let the surrounding datapath fill and drain the registers.

Top module: `vmm_unit`

## Requirements
- R1: A set-length command (opcode 1) takes the scalar operand as the new active length, raising 0 to 1 and lowering anything above 64 to 64. `vlen_o` shows the new value from the clock edge that accepts the command, and the length does not change while `busy` is high.
- R2: A test, compare or merge command (opcodes 2, 3, 4) is accepted on an edge where `cmd_valid` is high and `busy` is low. `busy` is then high for exactly as many cycles as the active length. `done` is high for the single cycle that follows. Commands presented while `busy` is high are ignored.
- R3: A merge writes destination elements 0 to length−1 only. Every destination element at or above the active length keeps its value.
- R4: A merge (opcode 4) writes destination element i from source 1 when mask bit i is 1, and from source 2 when it is 0.
- R5: A mask-load command (opcode 0) copies all 64 bits of the scalar operand into the mask, bit i to mask bit i, whatever the active length. `done` is high for one cycle after the accepting edge and `busy` stays low.
- R6: A test command (opcode 2) sets mask bit i from source-1 element i under condition code 0 = zero, 1 = nonzero, 2 = negative (bit 63 set), 3 = positive (bit 63 clear, so zero counts as positive). Mask bits at or above the active length end up 0.
- R7: A compare command (opcode 3) sets mask bit i when source-1 element i is less than source-2 element i as signed 64-bit values. Mask bits at or above the active length end up 0.
- R8: After reset, `busy`, `done` and the mask are 0 and the active length is 64.
- R9: While `busy` is high, external element writes have no effect. Opcodes 5 to 7 are ignored: they raise neither `busy` nor `done` and change no state.
- R10: The read port returns element `rd_idx` of register `rd_reg` in the same cycle, without a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Opcode: 0 load mask, 1 set length, 2 test, 3 compare, 4 merge |
| cmd_cond | input | 2 | Test condition code |
| cmd_dst | input | 3 | Merge destination register |
| cmd_src1 | input | 3 | Source 1 register |
| cmd_src2 | input | 3 | Source 2 register |
| cmd_scalar | input | 64 | Scalar operand for mask load and set length |
| busy | output | 1 | Element walk in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_en | input | 1 | External element write enable |
| wr_reg | input | 3 | External write register |
| wr_idx | input | 6 | External write element index |
| wr_data | input | 64 | External write data |
| rd_reg | input | 3 | Read register |
| rd_idx | input | 6 | Read element index |
| rd_data | output | 64 | Read data |
| mask_o | output | 64 | Current mask |
| vlen_o | output | 7 | Current active length |

## Verification
The mask and length are visible at the ports, and the bench's model predicts them on every clock. So a wrong mask bit, a length clamped the wrong way, or a stale bit above the length shows up within one cycle of the edge that produced it. An element counter that is off by one stretches or shortens `busy`, or moves the `done` pulse, and this is caught on the same clock. A merge that writes the wrong source or writes past the length only shows in the register contents. After each merge the bench reads back every element of the destination, so the error is caught when that command completes.

// File: rtl/vmm_pkg.sv
package vmm_pkg;
   typedef enum logic [2:0] {
      OP_LDMASK = 3'd0,
      OP_SETVL  = 3'd1,
      OP_TEST   = 3'd2,
      OP_CMPLT  = 3'd3,
      OP_MERGE  = 3'd4
   } vmm_op_e;

   typedef enum logic [1:0] {
      COND_ZERO    = 2'd0,
      COND_NONZERO = 2'd1,
      COND_NEG     = 2'd2,
      COND_POS     = 2'd3
   } vmm_cond_e;
endpackage

// File: rtl/vmm_vrf.sv
module vmm_vrf #(
   parameter int ELEM_W   = 64,
   parameter int NUM_VREG = 8,
   parameter int MAX_VL   = 64
) (
   input  logic                        clk,
   input  logic                        we_i,
   input  logic [$clog2(NUM_VREG)-1:0] wreg_i,
   input  logic [$clog2(MAX_VL)-1:0]   widx_i,
   input  logic [ELEM_W-1:0]           wdata_i,
   input  logic [$clog2(NUM_VREG)-1:0] a_reg_i,
   input  logic [$clog2(MAX_VL)-1:0]   a_idx_i,
   output logic [ELEM_W-1:0]           a_data_o,
   input  logic [$clog2(NUM_VREG)-1:0] b_reg_i,
   input  logic [$clog2(MAX_VL)-1:0]   b_idx_i,
   output logic [ELEM_W-1:0]           b_data_o,
   input  logic [$clog2(NUM_VREG)-1:0] c_reg_i,
   input  logic [$clog2(MAX_VL)-1:0]   c_idx_i,
   output logic [ELEM_W-1:0]           c_data_o
);
   localparam int RW = $clog2(NUM_VREG);

   logic [ELEM_W-1:0] a_col [NUM_VREG];
   logic [ELEM_W-1:0] b_col [NUM_VREG];
   logic [ELEM_W-1:0] c_col [NUM_VREG];

   // One storage bank per register; read columns are muxed by register index.
   for (genvar g = 0; g < NUM_VREG; g++) begin : g_reg
      logic [ELEM_W-1:0] mem [MAX_VL];
      always_ff @(posedge clk) begin
         if (we_i && (wreg_i == RW'(g))) mem[widx_i] <= wdata_i;
      end
      assign a_col[g] = mem[a_idx_i];
      assign b_col[g] = mem[b_idx_i];
      assign c_col[g] = mem[c_idx_i];
   end

   assign a_data_o = a_col[a_reg_i];
   assign b_data_o = b_col[b_reg_i];
   assign c_data_o = c_col[c_reg_i];
endmodule

// File: rtl/vmm_elem_alu.sv
module vmm_elem_alu
   import vmm_pkg::*;
#(
   parameter int ELEM_W     = 64,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic [ELEM_W-1:0] a_i,
   input  logic [ELEM_W-1:0] b_i,
   input  logic [1:0]        cond_i,
   input  logic              cmp_sel_i,
   input  logic              sel_i,
   output logic              mask_bit_o,
   output logic [ELEM_W-1:0] merge_o
);
   logic lt;
   logic tst;

   if (SIGNED_CMP) begin : g_scmp
      assign lt = $signed(a_i) < $signed(b_i);
   end else begin : g_ucmp
      assign lt = a_i < b_i;
   end

   always_comb begin
      unique case (vmm_cond_e'(cond_i))
         COND_ZERO:    tst = (a_i == '0);
         COND_NONZERO: tst = (a_i != '0);
         COND_NEG:     tst = a_i[ELEM_W-1];
         default:      tst = ~a_i[ELEM_W-1];
      endcase
   end

   assign mask_bit_o = cmp_sel_i ? lt : tst;
   assign merge_o    = sel_i ? a_i : b_i;
endmodule

// File: rtl/vmm_seq.sv
module vmm_seq #(
   parameter int MAX_VL = 64
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         start_i,
   input  logic [$clog2(MAX_VL+1)-1:0]  vlen_i,
   output logic                         busy_o,
   output logic [$clog2(MAX_VL)-1:0]    idx_o,
   output logic                         done_o
);
   localparam int VLW = $clog2(MAX_VL + 1);

   logic last;
   assign last = (VLW'(idx_o) == (vlen_i - VLW'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_o <= 1'b0;
         idx_o  <= '0;
         done_o <= 1'b0;
      end else begin
         done_o <= 1'b0;
         if (start_i) begin
            busy_o <= 1'b1;
            idx_o  <= '0;
         end else if (busy_o) begin
            if (last) begin
               busy_o <= 1'b0;
               done_o <= 1'b1;
               idx_o  <= '0;
            end else begin
               idx_o <= idx_o + 1'b1;
            end
         end
      end
   end

   assert_idx_below_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (VLW'(idx_o) < vlen_i));

   assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   assert_busy_fall_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> done_o);
endmodule

// File: rtl/vmm_unit.sv
module vmm_unit
   import vmm_pkg::*;
#(
   parameter int ELEM_W     = 64,
   parameter int MAX_VL     = 64,
   parameter int NUM_VREG   = 8,
   parameter bit SIGNED_CMP = 1'b1
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         cmd_valid,
   input  logic [2:0]                   cmd_op,
   input  logic [1:0]                   cmd_cond,
   input  logic [$clog2(NUM_VREG)-1:0]  cmd_dst,
   input  logic [$clog2(NUM_VREG)-1:0]  cmd_src1,
   input  logic [$clog2(NUM_VREG)-1:0]  cmd_src2,
   input  logic [ELEM_W-1:0]            cmd_scalar,
   output logic                         busy,
   output logic                         done,
   input  logic                         wr_en,
   input  logic [$clog2(NUM_VREG)-1:0]  wr_reg,
   input  logic [$clog2(MAX_VL)-1:0]    wr_idx,
   input  logic [ELEM_W-1:0]            wr_data,
   input  logic [$clog2(NUM_VREG)-1:0]  rd_reg,
   input  logic [$clog2(MAX_VL)-1:0]    rd_idx,
   output logic [ELEM_W-1:0]            rd_data,
   output logic [MAX_VL-1:0]            mask_o,
   output logic [$clog2(MAX_VL+1)-1:0]  vlen_o
);
   localparam int RW  = $clog2(NUM_VREG);
   localparam int IW  = $clog2(MAX_VL);
   localparam int VLW = $clog2(MAX_VL + 1);

   if (MAX_VL > ELEM_W) begin : g_bad_mask_w
      $error("mask must fit in one scalar operand");
   end
   if (NUM_VREG < 2) begin : g_bad_nreg
      $error("at least two vector registers are required");
   end

   vmm_op_e  op_in;
   vmm_op_e  op_q;
   logic [1:0]    cond_q;
   logic [RW-1:0] dst_q, s1_q, s2_q;
   logic [MAX_VL-1:0] mask_q;
   logic [VLW-1:0]    vlen_q;
   logic accept, elem_cmd, start, scal_done, seq_done;
   logic [IW-1:0] idx;
   logic int_we, rf_we;
   logic [RW-1:0] rf_wreg;
   logic [IW-1:0] rf_widx;
   logic [ELEM_W-1:0] rf_wdata, a_data, b_data, merge_val;
   logic alu_bit;
   logic [VLW-1:0] clamp_len;
   logic [MAX_VL-1:0] live_m;

   assign op_in    = vmm_op_e'(cmd_op);
   assign accept   = cmd_valid & ~busy;
   assign elem_cmd = (op_in == OP_TEST) || (op_in == OP_CMPLT) || (op_in == OP_MERGE);
   assign start    = accept & elem_cmd;

   always_comb begin
      if (cmd_scalar == '0)                     clamp_len = VLW'(1);
      else if (cmd_scalar > ELEM_W'(MAX_VL))    clamp_len = VLW'(MAX_VL);
      else                                      clamp_len = cmd_scalar[VLW-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q   <= OP_LDMASK;
         cond_q <= '0;
         dst_q  <= '0;
         s1_q   <= '0;
         s2_q   <= '0;
      end else if (start) begin
         op_q   <= op_in;
         cond_q <= cmd_cond;
         dst_q  <= cmd_dst;
         s1_q   <= cmd_src1;
         s2_q   <= cmd_src2;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vlen_q    <= VLW'(MAX_VL);
         mask_q    <= '0;
         scal_done <= 1'b0;
      end else begin
         scal_done <= accept && ((op_in == OP_LDMASK) || (op_in == OP_SETVL));
         if (accept) begin
            if (op_in == OP_LDMASK) mask_q <= cmd_scalar[MAX_VL-1:0];
            if (op_in == OP_SETVL)  vlen_q <= clamp_len;
            if ((op_in == OP_TEST) || (op_in == OP_CMPLT)) mask_q <= '0;
         end else if (busy && (op_q != OP_MERGE)) begin
            mask_q[idx] <= alu_bit;
         end
      end
   end

   vmm_seq #(.MAX_VL(MAX_VL)) seq_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start),
      .vlen_i  (vlen_q),
      .busy_o  (busy),
      .idx_o   (idx),
      .done_o  (seq_done)
   );

   assign int_we   = busy && (op_q == OP_MERGE);
   assign rf_we    = int_we | (wr_en & ~busy);
   assign rf_wreg  = int_we ? dst_q     : wr_reg;
   assign rf_widx  = int_we ? idx       : wr_idx;
   assign rf_wdata = int_we ? merge_val : wr_data;

   vmm_vrf #(.ELEM_W(ELEM_W), .NUM_VREG(NUM_VREG), .MAX_VL(MAX_VL)) vrf_i (
      .clk      (clk),
      .we_i     (rf_we),
      .wreg_i   (rf_wreg),
      .widx_i   (rf_widx),
      .wdata_i  (rf_wdata),
      .a_reg_i  (s1_q),
      .a_idx_i  (idx),
      .a_data_o (a_data),
      .b_reg_i  (s2_q),
      .b_idx_i  (idx),
      .b_data_o (b_data),
      .c_reg_i  (rd_reg),
      .c_idx_i  (rd_idx),
      .c_data_o (rd_data)
   );

   vmm_elem_alu #(.ELEM_W(ELEM_W), .SIGNED_CMP(SIGNED_CMP)) alu_i (
      .a_i        (a_data),
      .b_i        (b_data),
      .cond_i     (cond_q),
      .cmp_sel_i  (op_q == OP_CMPLT),
      .sel_i      (mask_q[idx]),
      .mask_bit_o (alu_bit),
      .merge_o    (merge_val)
   );

   assign done   = seq_done | scal_done;
   assign mask_o = mask_q;
   assign vlen_o = vlen_q;

   always_comb begin
      for (int i = 0; i < MAX_VL; i++) live_m[i] = (i < int'(vlen_q));
   end

   assert_len_stable_R1: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(vlen_q));

   assert_mask_tail_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (seq_done && (op_q != OP_MERGE)) |-> ((mask_q & ~live_m) == '0));

   assert_merge_keeps_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && (op_q == OP_MERGE)) |-> $stable(mask_q));
endmodule

// File: tb/vmm_unit_tb_top.sv
`timescale 1ns/1ps
module vmm_unit_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [2:0] cmd_op = '0;
   logic [1:0] cmd_cond = '0;
   logic [2:0] cmd_dst = '0, cmd_src1 = '0, cmd_src2 = '0;
   logic [63:0] cmd_scalar = '0;
   logic busy, done;
   logic wr_en = 1'b0;
   logic [2:0] wr_reg = '0;
   logic [5:0] wr_idx = '0;
   logic [63:0] wr_data = '0;
   logic [2:0] rd_reg = '0;
   logic [5:0] rd_idx = '0;
   logic [63:0] rd_data;
   logic [63:0] mask_o;
   logic [6:0] vlen_o;

   always #2 clk = ~clk;

   vmm_unit dut_i (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_cond(cmd_cond), .cmd_dst(cmd_dst), .cmd_src1(cmd_src1),
      .cmd_src2(cmd_src2), .cmd_scalar(cmd_scalar), .busy(busy), .done(done),
      .wr_en(wr_en), .wr_reg(wr_reg), .wr_idx(wr_idx), .wr_data(wr_data),
      .rd_reg(rd_reg), .rd_idx(rd_idx), .rd_data(rd_data),
      .mask_o(mask_o), .vlen_o(vlen_o)
   );

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   string cur_req = "R8";

   logic [63:0] ref_rf [8][64];
   logic [63:0] m_mask = '0;
   int m_vl = 64;
   bit m_busy = 0;
   bit m_done = 0;

   task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", cur_req, what, act, exp);
      end
   endtask

   task automatic check_ports();
      chk("busy(R2)", 64'(busy), 64'(m_busy));
      chk("done(R2)", 64'(done), 64'(m_done));
      chk("mask", mask_o, m_mask);
      chk("vlen(R1)", 64'(vlen_o), 64'(m_vl));
   endtask

   function automatic logic [63:0] pat(input int r, input int i);
      logic [63:0] v;
      v = {32'(r * 1000 + i) * 32'd2654435761, 32'(r * 40503 + i * 977 + 7)};
      if ((i + r) % 7 == 0) v = '0;
      else if ((i + r) % 3 == 0) v = -64'(i * 17 + r);
      return v;
   endfunction

   function automatic int clamp(input logic [63:0] s);
      if (s == 0) return 1;
      if (s > 64) return 64;
      return int'(s);
   endfunction

   function automatic bit cond_hit(input logic [63:0] a, input int c);
      case (c)
         0: return a == 0;
         1: return a != 0;
         2: return a[63];
         default: return !a[63];
      endcase
   endfunction

   task automatic ext_write(input int r, input int i, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1; wr_reg = 3'(r); wr_idx = 6'(i); wr_data = d;
      @(posedge clk); #1;
      wr_en = 0;
      ref_rf[r][i] = d;
   endtask

   task automatic check_reg(input int r);
      for (int i = 0; i < 64; i++) begin
         rd_reg = 3'(r); rd_idx = 6'(i);
         #0.1;
         chk($sformatf("v%0d[%0d] (R10)", r, i), rd_data, ref_rf[r][i]);
      end
   endtask

   task automatic issue(input int op, input int cond, input int dst, input int s1,
                        input int s2, input logic [63:0] sc, input bit poke);
      int k;
      @(negedge clk);
      cmd_valid = 1; cmd_op = 3'(op); cmd_cond = 2'(cond);
      cmd_dst = 3'(dst); cmd_src1 = 3'(s1); cmd_src2 = 3'(s2); cmd_scalar = sc;
      @(posedge clk); #1;
      cmd_valid = 0;
      m_done = 0;
      k = 0;
      case (op)
         0: begin m_mask = sc; m_done = 1; end
         1: begin m_vl = clamp(sc); m_done = 1; end
         2, 3: begin m_busy = 1; m_mask = '0; end
         4: m_busy = 1;
         default: ;
      endcase
      @(negedge clk);
      check_ports();
      if (poke && m_busy) begin
         cmd_valid = 1; cmd_op = 3'd0; cmd_scalar = '1;
         wr_en = 1; wr_reg = 3'(dst); wr_idx = 6'd63; wr_data = 64'hDEAD_BEEF_0000_0001;
      end
      while (m_busy) begin
         logic [63:0] a, b;
         @(posedge clk); #1;
         cmd_valid = 0; wr_en = 0;
         a = ref_rf[s1][k];
         b = ref_rf[s2][k];
         if (op == 2) m_mask[k] = cond_hit(a, cond);
         else if (op == 3) m_mask[k] = ($signed(a) < $signed(b));
         else ref_rf[dst][k] = m_mask[k] ? a : b;
         k++;
         if (k == m_vl) begin m_busy = 0; m_done = 1; end
         @(negedge clk);
         check_ports();
      end
      @(posedge clk); #1;
      m_done = 0;
      @(negedge clk);
      check_ports();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=hung expected=complete");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1;
      // R8: reset state
      cur_req = "R8";
      @(negedge clk);
      check_ports();

      for (int r = 0; r < 8; r++)
         for (int i = 0; i < 64; i++) ext_write(r, i, pat(r, i));
      cur_req = "R10";
      check_reg(0);
      check_reg(7);

      // R1: length clamping
      cur_req = "R1";
      issue(1, 0, 0, 0, 0, 64'd0, 0);
      issue(1, 0, 0, 0, 0, 64'd100, 0);
      issue(1, 0, 0, 0, 0, 64'h8000_0000_0000_0005, 0);
      issue(1, 0, 0, 0, 0, 64'd37, 0);

      // R5: full-width mask load regardless of length
      cur_req = "R5";
      issue(0, 0, 0, 0, 0, 64'hA5A5_0F0F_1234_8001, 0);

      // R6: each condition, short and full length
      cur_req = "R6";
      for (int c = 0; c < 4; c++) issue(2, c, 0, 0, 0, '0, 0);
      issue(1, 0, 0, 0, 0, 64'd64, 0);
      for (int c = 0; c < 4; c++) issue(2, c, 0, 3, 0, '0, 0);

      // R7: signed compare, then R4 merge gives element-wise minimum
      cur_req = "R7";
      issue(3, 0, 0, 2, 3, '0, 0);
      cur_req = "R4";
      issue(4, 0, 2, 2, 3, '0, 0);
      check_reg(2);

      // R3: merge under a short length leaves the tail alone
      cur_req = "R3";
      issue(1, 0, 0, 0, 0, 64'd37, 0);
      issue(0, 0, 0, 0, 0, 64'hFFFF_0000_F0F0_3C3C, 0);
      issue(4, 0, 5, 0, 1, '0, 0);
      check_reg(5);
      issue(1, 0, 0, 0, 0, 64'd1, 0);
      issue(4, 0, 6, 1, 4, '0, 0);
      check_reg(6);

      // R9: commands and writes during busy, unused opcodes
      cur_req = "R9";
      issue(1, 0, 0, 0, 0, 64'd20, 0);
      issue(3, 0, 0, 4, 1, '0, 0);
      issue(4, 0, 4, 0, 1, '0, 1);
      check_reg(4);
      issue(5, 0, 0, 0, 0, '1, 0);
      issue(7, 0, 0, 0, 0, '1, 0);
      check_reg(0);

      // R2: back-to-back element commands at full length
      cur_req = "R2";
      issue(1, 0, 0, 0, 0, 64'd64, 0);
      issue(3, 0, 0, 1, 0, '0, 0);
      issue(4, 0, 7, 1, 0, '0, 0);
      check_reg(7);

      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule